// File: doc/BRIEF.md
# I2C Slave Receiver with 7-bit and 10-bit Addressing

This block is the receive side of an I2C slave. It watches SCL and SDA, which arrive already synchronized to the system clock. It finds START and STOP conditions, and it decides whether the first byte after a START selects this device. When the device is selected, it pulls SDA low through an open-drain enable so that the master sees an acknowledge. Each byte is shifted in MSB first and then copied into a single holding buffer. The next byte can therefore be shifted in while the host has not yet read the previous one.

A small host register file holds the following:

- an enable bit
- a four-bit mode code
- a sticky overflow flag
- a read-only status register
- the receive buffer
- one address register

In 10-bit mode the host loads the address register in two steps. It first writes the high byte, which has the form `11110 A9 A8 0`. After that byte has matched, it writes the low eight address bits. A one-cycle interrupt pulse is raised when a byte lands in the buffer. It is also raised on START and STOP in the modes that ask for it.

Top module: `i2c_slave_rx`

## Requirements
- R1: After reset, the control, status and buffer registers read 0x00, `sda_oe_o` is low and `irq_o` is low. While the enable bit (ctrl bit 7) is 0, no byte is acknowledged, no interrupt is raised and the status register reads 0x00.
- R2: A START (SDA falls while SCL is high) sets status bit 0 and clears status bit 1. A STOP (SDA rises while SCL is high) sets status bit 1 and clears status bit 0.
- R3: In 7-bit mode (mode 4'b0001 or 4'b0101), bits 7:1 of the first byte after a START are compared with bits 7:1 of the address register.
  - On a match, SDA is held low during the ninth SCL pulse.
  - The byte is loaded into the buffer (register 2).
  - Status bit 2 reads 0, which marks an address byte.
  - Status bit 4 takes bit 0 of the byte (R/W).
- R4: An address that does not match is never acknowledged. The general call address 0x00 is never acknowledged, even when the address register holds 0x00. After a byte that was not acknowledged, every byte up to the next START or STOP is neither acknowledged nor loaded.
- R5: After a matched address, each data byte is assembled MSB first and loaded into the buffer. The load sets status bit 5 (buffer full) and status bit 2 (data byte), acknowledges the byte and gives one `irq_o` pulse.
- R6: A host read of register 2 clears the buffer-full bit. A byte that completes while the buffer is full does the following:
  - it is not acknowledged;
  - it raises no interrupt;
  - it is discarded, so the buffer keeps its old byte;
  - it sets the overflow flag, ctrl bit 6.
- R7: A control write with bit 6 at 0 clears the overflow flag. A control write with bit 6 at 1 leaves the flag unchanged.
- R8: In 10-bit mode (mode 4'b0010 or 4'b0110), the first address byte matches when its bits 7:1 equal bits 7:1 of the address register and its bit 0 is 0. The match sets status bit 3, which means the next byte completes the address. That next byte is then compared with all eight bits of the address register as reloaded by the host. A match acknowledges it, clears status bit 3 and selects the device for the data bytes that follow.
- R9: In 10-bit mode, a high byte whose A9:A8 bits differ from the address register is not acknowledged, and neither is a low byte that does not match. No later byte of that transfer is acknowledged.
- R10: In modes 4'b0101 and 4'b0110, every START and every STOP gives one `irq_o` pulse. In modes 4'b0001 and 4'b0010 they give none.
- R11: In mode 4'b1000 (host-driven master, slave idle), START and STOP still update status bits 0 and 1. No byte is acknowledged or loaded, and no interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level (wired bus value) |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| irq_o | output | 1 | One-cycle interrupt pulse |
| reg_wr_i | input | 1 | Host write strobe |
| reg_rd_i | input | 1 | Host read strobe (a read of register 2 clears buffer full) |
| reg_addr_i | input | 2 | Register select: 0 ctrl, 1 status, 2 buffer, 3 address |
| reg_wdata_i | input | 8 | Host write data |
| reg_rdata_o | output | 8 | Host read data for the selected register |

## Verification
The bench sends a second byte while the first is still unread. A design that overwrote the buffer, or that still acknowledged the byte, would show the wrong buffer value or an ACK where a NACK is expected.

It sends the general call address with the address register holding zero. A comparator with no guard for zero would acknowledge it.

It also runs the 10-bit sequence with the address register reloaded between the two address bytes, once with a matching low byte and once with a mismatching one. This catches an engine that skips the second compare, or that never clears the "next byte completes the address" bit.

Finally, it checks that interrupts on START and STOP depend on the mode code, and that master mode tracks START and STOP but never pulls SDA.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;

  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam int MODE_W = 4;
  localparam int REG_AW = 2;

  // host register select
  localparam logic [REG_AW-1:0] RA_CTRL = 2'd0;
  localparam logic [REG_AW-1:0] RA_STAT = 2'd1;
  localparam logic [REG_AW-1:0] RA_BUF  = 2'd2;
  localparam logic [REG_AW-1:0] RA_ADR  = 2'd3;

  // control bit positions
  localparam int CB_EN  = 7;
  localparam int CB_OVF = 6;

  // status bit positions
  localparam int SB_START = 0;
  localparam int SB_STOP  = 1;
  localparam int SB_DATA  = 2;
  localparam int SB_LONXT = 3;
  localparam int SB_RW    = 4;
  localparam int SB_FULL  = 5;

  typedef enum logic [MODE_W-1:0] {
    MODE_SL7     = 4'b0001,
    MODE_SL10    = 4'b0010,
    MODE_SL7_SP  = 4'b0101,
    MODE_SL10_SP = 4'b0110,
    MODE_FW_MST  = 4'b1000
  } mode_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_ADDR_LO,
    PH_DATA,
    PH_SKIP
  } phase_e;

  function automatic logic mode_is_slave(input logic [MODE_W-1:0] m);
    return (m == MODE_SL7) || (m == MODE_SL10) ||
           (m == MODE_SL7_SP) || (m == MODE_SL10_SP);
  endfunction

  function automatic logic mode_is_ten(input logic [MODE_W-1:0] m);
    return (m == MODE_SL10) || (m == MODE_SL10_SP);
  endfunction

  function automatic logic mode_sp_irq(input logic [MODE_W-1:0] m);
    return (m == MODE_SL7_SP) || (m == MODE_SL10_SP);
  endfunction

endpackage

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  // SDA edge with SCL steady high
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;

endmodule

// File: rtl/i2c_rx_engine.sv
module i2c_rx_engine
  import i2c_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slave_en_i,
  input  logic              ten_bit_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              sda_i,
  input  logic [BYTE_W-1:0] addr_reg_i,
  input  logic              buf_full_i,
  output logic              load_o,
  output logic              drop_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              addr_byte_o,
  output logic              lo_next_o,
  output logic              rw_upd_o,
  output logic              sda_oe_o
);

  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);

  phase_e            phase_q, nxt_phase;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] shift_q, rx_byte;
  logic              ack_q, oe_q;
  logic              byte_done, hit, is_addr, lo_next, accept;

  assign rx_byte   = {shift_q[BYTE_W-2:0], sda_i};
  assign byte_done = scl_rise_i && (cnt_q == LAST_BIT) &&
                     (phase_q == PH_ADDR || phase_q == PH_ADDR_LO || phase_q == PH_DATA);

  always_comb begin
    hit       = 1'b0;
    is_addr   = 1'b1;
    lo_next   = 1'b0;
    nxt_phase = phase_q;
    unique case (phase_q)
      PH_ADDR: begin
        if (ten_bit_i) begin
          hit       = (rx_byte[BYTE_W-1:1] == addr_reg_i[BYTE_W-1:1]) && !rx_byte[0];
          lo_next   = 1'b1;
          nxt_phase = PH_ADDR_LO;
        end else begin
          // general call never matches
          hit       = (rx_byte[BYTE_W-1:1] == addr_reg_i[BYTE_W-1:1]) &&
                      (rx_byte[BYTE_W-1:1] != '0);
          nxt_phase = PH_DATA;
        end
      end
      PH_ADDR_LO: begin
        hit       = (rx_byte == addr_reg_i);
        nxt_phase = PH_DATA;
      end
      PH_DATA: begin
        hit     = 1'b1;
        is_addr = 1'b0;
      end
      default: ;
    endcase
  end

  assign accept      = byte_done && hit && !buf_full_i;
  assign load_o      = accept;
  assign drop_o      = byte_done && hit && buf_full_i;
  assign byte_o      = rx_byte;
  assign addr_byte_o = is_addr;
  assign lo_next_o   = lo_next;
  assign rw_upd_o    = accept && (phase_q == PH_ADDR) && !ten_bit_i;
  assign sda_oe_o    = oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      shift_q <= '0;
      ack_q   <= 1'b0;
      oe_q    <= 1'b0;
    end else if (!slave_en_i) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      ack_q   <= 1'b0;
      oe_q    <= 1'b0;
    end else if (start_i) begin
      phase_q <= PH_ADDR;
      cnt_q   <= '0;
      ack_q   <= 1'b0;
      oe_q    <= 1'b0;
    end else if (stop_i) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      ack_q   <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      if (scl_rise_i && phase_q != PH_IDLE) begin
        if (cnt_q == ACK_SLOT) begin
          cnt_q <= '0;
          ack_q <= 1'b0;
        end else begin
          cnt_q   <= cnt_q + 1'b1;
          shift_q <= rx_byte;
        end
        if (byte_done) begin
          ack_q <= accept;
          if (accept)                 phase_q <= nxt_phase;
          else if (phase_q != PH_DATA) phase_q <= PH_SKIP;
        end
      end
      // ACK drive from the fall after bit 0 to the fall after the ninth pulse
      if (scl_fall_i) oe_q <= (cnt_q == ACK_SLOT) && ack_q;
    end
  end

endmodule

// File: rtl/i2c_slave_rx.sv
module i2c_slave_rx
  import i2c_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic              irq_o,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [BYTE_W-1:0] reg_wdata_i,
  output logic [BYTE_W-1:0] reg_rdata_o
);

  logic              en_q, ovf_q;
  logic [MODE_W-1:0] mode_q;
  logic [BYTE_W-1:0] addr_q, buf_q;
  logic              full_q, s_q, p_q, dat_q, lo_q, rw_q, irq_q;

  logic              scl_rise, scl_fall, start_det, stop_det;
  logic              slave_en;
  logic              load, drop, addr_byte, lo_next, rw_upd;
  logic [BYTE_W-1:0] rx_byte;
  logic              ctrl_wr;

  assign slave_en = en_q && mode_is_slave(mode_q);
  assign ctrl_wr  = reg_wr_i && (reg_addr_i == RA_CTRL);

  i2c_bus_cond u_cond (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  i2c_rx_engine u_eng (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .slave_en_i  (slave_en),
    .ten_bit_i   (mode_is_ten(mode_q)),
    .scl_rise_i  (scl_rise),
    .scl_fall_i  (scl_fall),
    .start_i     (start_det),
    .stop_i      (stop_det),
    .sda_i       (sda_i),
    .addr_reg_i  (addr_q),
    .buf_full_i  (full_q),
    .load_o      (load),
    .drop_o      (drop),
    .byte_o      (rx_byte),
    .addr_byte_o (addr_byte),
    .lo_next_o   (lo_next),
    .rw_upd_o    (rw_upd),
    .sda_oe_o    (sda_oe_o)
  );

  // host-owned control and address
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      mode_q <= '0;
      ovf_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      if (ctrl_wr) begin
        en_q   <= reg_wdata_i[CB_EN];
        mode_q <= reg_wdata_i[MODE_W-1:0];
      end
      if (drop)                             ovf_q <= 1'b1;
      else if (ctrl_wr && !reg_wdata_i[CB_OVF]) ovf_q <= 1'b0;
      if (reg_wr_i && reg_addr_i == RA_ADR) addr_q <= reg_wdata_i;
    end
  end

  // receive buffer and status
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q  <= '0;
      full_q <= 1'b0;
      s_q    <= 1'b0;
      p_q    <= 1'b0;
      dat_q  <= 1'b0;
      lo_q   <= 1'b0;
      rw_q   <= 1'b0;
      irq_q  <= 1'b0;
    end else if (!en_q) begin
      full_q <= 1'b0;
      s_q    <= 1'b0;
      p_q    <= 1'b0;
      dat_q  <= 1'b0;
      lo_q   <= 1'b0;
      rw_q   <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (start_det) begin
        s_q <= 1'b1;
        p_q <= 1'b0;
      end else if (stop_det) begin
        p_q <= 1'b1;
        s_q <= 1'b0;
      end
      if (load) begin
        buf_q  <= rx_byte;
        full_q <= 1'b1;
        dat_q  <= !addr_byte;
        lo_q   <= lo_next;
      end else if (reg_rd_i && reg_addr_i == RA_BUF) begin
        full_q <= 1'b0;
      end
      if (rw_upd) rw_q <= rx_byte[0];
      irq_q <= load || (mode_sp_irq(mode_q) && (start_det || stop_det));
    end
  end

  assign irq_o = irq_q;

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      RA_CTRL: begin
        reg_rdata_o[CB_EN]        = en_q;
        reg_rdata_o[CB_OVF]       = ovf_q;
        reg_rdata_o[MODE_W-1:0]   = mode_q;
      end
      RA_STAT: begin
        reg_rdata_o[SB_START] = s_q;
        reg_rdata_o[SB_STOP]  = p_q;
        reg_rdata_o[SB_DATA]  = dat_q;
        reg_rdata_o[SB_LONXT] = lo_q;
        reg_rdata_o[SB_RW]    = rw_q;
        reg_rdata_o[SB_FULL]  = full_q;
      end
      RA_BUF:  reg_rdata_o = buf_q;
      default: reg_rdata_o = addr_q;
    endcase
  end

endmodule

// File: rtl/i2c_slave_rx_chk.sv
module i2c_slave_rx_chk
  import i2c_rx_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_q,
  input logic              sda_oe_o,
  input logic              scl_fall,
  input logic              start_det,
  input logic              stop_det,
  input logic              s_q,
  input logic              p_q,
  input logic              load,
  input logic              drop,
  input logic              full_q,
  input logic              ovf_q,
  input logic [BYTE_W-1:0] buf_q
);

  assert_oe_needs_en_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |=> !sda_oe_o);

  assert_ack_on_fall_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> $past(scl_fall));

  assert_start_flag_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && start_det) |=> (s_q && !p_q));

  assert_stop_flag_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && stop_det) |=> (p_q && !s_q));

  assert_load_fills_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && load) |=> full_q);

  assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop |=> (ovf_q && $stable(buf_q)));

endmodule

bind i2c_slave_rx i2c_slave_rx_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_q      (en_q),
  .sda_oe_o  (sda_oe_o),
  .scl_fall  (scl_fall),
  .start_det (start_det),
  .stop_det  (stop_det),
  .s_q       (s_q),
  .p_q       (p_q),
  .load      (load),
  .drop      (drop),
  .full_q    (full_q),
  .ovf_q     (ovf_q),
  .buf_q     (buf_q)
);

// File: tb/test_i2c_slave_rx.sv
module test_i2c_slave_rx;

  localparam int Q = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_oe;
  logic       irq;
  logic       wr = 1'b0, rd = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       sda_bus;

  int n_chk = 0, n_fail = 0, irq_cnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;

  i2c_slave_rx i_i2c_slave_rx (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .scl_i       (scl_m),
    .sda_i       (sda_bus),
    .sda_oe_o    (sda_oe),
    .irq_o       (irq),
    .reg_wr_i    (wr),
    .reg_rd_i    (rd),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata)
  );

  always @(posedge clk) if (irq) irq_cnt <= irq_cnt + 1;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_q(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic host_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_q(Q);
    scl_m = 1'b1; wait_q(Q);
    sda_m = 1'b0; wait_q(Q);
    scl_m = 1'b0; wait_q(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_q(Q);
    scl_m = 1'b1; wait_q(Q);
    sda_m = 1'b1; wait_q(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic [7:0] ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wait_q(Q);
      scl_m = 1'b1; wait_q(2*Q);
      scl_m = 1'b0; wait_q(Q);
    end
    sda_m = 1'b1; wait_q(Q);
    scl_m = 1'b1; wait_q(Q);
    ack = {7'd0, ~sda_bus};
    wait_q(Q);
    scl_m = 1'b0; wait_q(Q);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    host_rd(0, d); chk("R1 ctrl reset", d, 8'h00);
    host_rd(1, d); chk("R1 status reset", d, 8'h00);
    host_rd(2, d); chk("R1 buffer reset", d, 8'h00);
    chk("R1 sda_oe reset", {7'd0, sda_oe}, 8'h00);
    chk("R1 irq reset", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_disabled();
    logic [7:0] d, a; int i0;
    host_wr(3, 8'hA0);
    host_wr(0, 8'h01);
    i0 = irq_cnt;
    bus_start();
    send_byte(8'hA0, a); chk("R1 no ack when disabled", a, 8'h00);
    host_rd(1, d); chk("R1 status idle when disabled", d, 8'h00);
    bus_stop();
    chk("R1 no irq when disabled", 8'(irq_cnt - i0), 8'h00);
  endtask

  task automatic t_seven_bit();
    logic [7:0] d, a; int i0;
    host_wr(0, 8'h81);
    bus_start();
    host_rd(1, d); chk("R2 start flag", d, 8'h01);
    i0 = irq_cnt;
    send_byte(8'hA0, a); chk("R3 addr ack", a, 8'h01);
    host_rd(1, d); chk("R3 status after addr", d, 8'h21);
    host_rd(2, d); chk("R3 addr in buffer", d, 8'hA0);
    send_byte(8'h3C, a); chk("R5 data ack", a, 8'h01);
    host_rd(1, d); chk("R5 status after data", d, 8'h25);
    host_rd(2, d); chk("R5 data byte MSB first", d, 8'h3C);
    chk("R5 irq per byte", 8'(irq_cnt - i0), 8'h02);
    host_rd(1, d); chk("R6 read clears full", d & 8'h20, 8'h00);
    bus_stop();
    host_rd(1, d); chk("R2 stop flag", d, 8'h06);
    bus_start();
    send_byte(8'hA1, a); chk("R3 read-direction addr ack", a, 8'h01);
    host_rd(1, d); chk("R3 rw status bit", d, 8'h31);
    host_rd(2, d);
    bus_stop();
  endtask

  task automatic t_overflow();
    logic [7:0] d, a; int i0;
    bus_start();
    send_byte(8'hA0, a); chk("R3 addr ack before overflow", a, 8'h01);
    i0 = irq_cnt;
    send_byte(8'h11, a); chk("R6 nack on overflow", a, 8'h00);
    chk("R6 no irq on dropped byte", 8'(irq_cnt - i0), 8'h00);
    host_rd(0, d); chk("R6 overflow flag", d, 8'hC1);
    host_wr(0, 8'hC1);
    host_rd(0, d); chk("R7 write one keeps flag", d, 8'hC1);
    host_rd(2, d); chk("R6 buffer keeps old byte", d, 8'hA0);
    host_wr(0, 8'h81);
    host_rd(0, d); chk("R7 write zero clears flag", d, 8'h81);
    send_byte(8'h22, a); chk("R6 ack after buffer read", a, 8'h01);
    host_rd(2, d); chk("R6 new byte loaded", d, 8'h22);
    bus_stop();
  endtask

  task automatic t_mismatch();
    logic [7:0] a; int i0;
    i0 = irq_cnt;
    bus_start();
    send_byte(8'hB0, a); chk("R4 mismatch nack", a, 8'h00);
    send_byte(8'h55, a); chk("R4 later byte ignored", a, 8'h00);
    bus_stop();
    chk("R4 no irq on mismatch", 8'(irq_cnt - i0), 8'h00);
    host_wr(3, 8'h00);
    bus_start();
    send_byte(8'h00, a); chk("R4 general call nack", a, 8'h00);
    bus_stop();
    host_wr(3, 8'hA0);
  endtask

  task automatic t_ten_bit();
    logic [7:0] d, a;
    host_wr(0, 8'h82);
    host_wr(3, 8'hF4);
    bus_start();
    send_byte(8'hF4, a); chk("R8 high byte ack", a, 8'h01);
    host_rd(1, d); chk("R8 low-next status", d, 8'h29);
    host_rd(2, d); chk("R8 high byte in buffer", d, 8'hF4);
    host_wr(3, 8'h5A);
    send_byte(8'h5A, a); chk("R8 low byte ack", a, 8'h01);
    host_rd(1, d); chk("R8 low-next cleared", d, 8'h21);
    host_rd(2, d);
    send_byte(8'h99, a); chk("R8 data after 10-bit addr", a, 8'h01);
    host_rd(2, d); chk("R8 data value", d, 8'h99);
    bus_stop();

    host_wr(3, 8'hF4);
    bus_start();
    send_byte(8'hF4, a);
    host_rd(2, d);
    host_wr(3, 8'h5A);
    send_byte(8'h5B, a); chk("R9 low byte mismatch nack", a, 8'h00);
    send_byte(8'h12, a); chk("R9 later byte ignored", a, 8'h00);
    bus_stop();

    host_wr(3, 8'hF4);
    bus_start();
    send_byte(8'hF6, a); chk("R9 high byte A9:A8 mismatch", a, 8'h00);
    bus_stop();
  endtask

  task automatic t_irq_modes();
    int i0;
    host_wr(0, 8'h85);
    i0 = irq_cnt;
    bus_start();
    chk("R10 irq on start", 8'(irq_cnt - i0), 8'h01);
    bus_stop();
    chk("R10 irq on stop", 8'(irq_cnt - i0), 8'h02);
    host_wr(0, 8'h81);
    i0 = irq_cnt;
    bus_start();
    bus_stop();
    chk("R10 no start/stop irq in plain mode", 8'(irq_cnt - i0), 8'h00);
  endtask

  task automatic t_master();
    logic [7:0] d, a; int i0;
    host_wr(0, 8'h88);
    i0 = irq_cnt;
    bus_start();
    host_rd(1, d); chk("R11 start tracked", d & 8'h03, 8'h01);
    send_byte(8'hA0, a); chk("R11 no ack in master mode", a, 8'h00);
    host_rd(1, d); chk("R11 nothing loaded", d & 8'h20, 8'h00);
    bus_stop();
    host_rd(1, d); chk("R11 stop tracked", d & 8'h03, 8'h02);
    chk("R11 no irq", 8'(irq_cnt - i0), 8'h00);
    host_wr(0, 8'h00);
    host_rd(1, d); chk("R1 status cleared on disable", d, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_disabled();
    t_seven_bit();
    t_overflow();
    t_mismatch();
    t_ten_bit();
    t_irq_modes();
    t_master();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule